// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative translation cache. A lookup presents a virtual address, an address-space identifier and an access kind. In the same cycle, every entry compares its page number and identifier against the request in parallel. On a match the stored frame number is joined to the untouched page offset to form the physical address, and no memory access is needed. Each entry also carries protection bits. An access those bits do not allow returns a fault instead of an address.

After a miss, the surrounding logic fetches the translation and writes it through the refill port. The entry that receives it is chosen by a round-robin pointer that steps over wired entries. Wired entries stay resident: replacement never picks them and flushes never clear them. Entries are tagged with their identifier, so a context switch needs no flush. Two flush commands are provided: one clears every non-wired entry, and the other clears only the non-wired entries that belong to one identifier.

Top module: `asid_tlb`

## Requirements
- R1: When `lk_valid` is 1 and a valid entry has the same page number (`lk_va[VA_W-1:OFF_W]`) and the same identifier, and the access is permitted, `lk_hit` is 1 in that same cycle. `lk_pa` then equals `{frame, lk_va[OFF_W-1:0]}`, and both `lk_miss` and `lk_fault` are 0.
- R2: When `lk_valid` is 1 and no valid entry matches both page number and identifier, `lk_miss` is 1 and `lk_hit`, `lk_fault` and `lk_pa` are all 0. An entry whose page number matches but whose identifier differs does not hit.
- R3: A refill that is accepted at a clock edge makes later lookups of that page number and identifier hit with the new frame and protection bits. A refill of a pair that is already present overwrites that entry in place, including its wired flag. It creates no second copy and leaves the pointer unchanged.
- R4: A refill of a new pair goes to the first non-wired entry at or after the round-robin pointer, wrapping at `ENTRIES`. The pointer then moves to that entry's index plus one, modulo `ENTRIES`. Reset sets the pointer to 0.
- R5: A wired entry is never chosen as a victim, and no flush command clears it. It changes only when a refill of its own pair overwrites it.
- R6: If every entry is wired and a refill presents a pair that is not present, `rf_err` is 1 in that cycle and the refill changes nothing. `rf_err` is 0 at all other times.
- R7: Access codes on `lk_acc` are 0 = read, 1 = write, 2 = execute and 3 = reserved. An entry with `rf_xo` = 1 allows only execute. An entry with `rf_xo` = 0 allows read, and also allows write when `rf_rw` = 1; it never allows execute. Code 3 is never allowed. On a match that is not allowed, `lk_fault` is 1, and `lk_hit`, `lk_miss` and `lk_pa` are 0.
- R8: Asserting `fl_all` for one cycle clears the valid bit of every non-wired entry.
- R9: Asserting `fl_asid_en` for one cycle clears every non-wired entry whose identifier equals `fl_asid`. Entries with other identifiers stay valid.
- R10: After reset no entry is valid. While `lk_valid` is 0, `lk_hit`, `lk_miss`, `lk_fault` and `lk_pa` are all 0.
- R11: When a flush and a refill share a cycle, the flush is applied first and the refill is then written. The refilled entry is valid afterwards. A lookup made in the same cycle as a refill or flush sees the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_va | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Identifier of the requesting address space |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Matching entry forbids this access |
| lk_pa | output | PA_W | Physical address; 0 unless `lk_hit` |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | VA_W-OFF_W | Page number to install |
| rf_asid | input | ASID_W | Identifier to install |
| rf_pfn | input | PA_W-OFF_W | Frame number to install |
| rf_rw | input | 1 | Entry is writable |
| rf_xo | input | 1 | Entry is execute-only |
| rf_wired | input | 1 | Entry is wired (exempt from replacement and flush) |
| rf_err | output | 1 | Refill rejected because all entries are wired |
| fl_all | input | 1 | Flush every non-wired entry |
| fl_asid_en | input | 1 | Flush non-wired entries of one identifier |
| fl_asid | input | ASID_W | Identifier to flush |

## Verification
Several properties are checked on every cycle. At most one entry matches any lookup or refill key. A fault never appears together with a hit or a miss. The chosen victim is never wired, and a wired entry stays valid and wired unless its own pair is rewritten. After a flush-all with no refill, only wired entries remain valid, and a rejected refill leaves the pointer unchanged. Some behaviours need the bench's scenarios to show them: the exact round-robin sequence of victims, overwriting an existing pair in place, the selectivity of a flush by identifier, the protection decision for each access kind, and the flush-then-write order when a flush and a refill share a cycle. A randomized reference model covers these, together with directed cases for the all-wired and flush-plus-refill corners.

// File: rtl/asid_tlb_pkg.sv
`timescale 1ns/1ps
package asid_tlb_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic rw;   // writable
        logic xo;   // execute-only
    } perm_t;

endpackage

// File: rtl/tlb_cam.sv
`timescale 1ns/1ps
// Parallel key compare across all entries; reports a match vector,
// whether any entry matched and the encoded index of the match.
module tlb_cam #(
    parameter int N     = 16,
    parameter int KEY_W = 28,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            valid_i,
    input  logic [N-1:0][KEY_W-1:0] keys_i,
    input  logic [KEY_W-1:0]        key_i,
    output logic [N-1:0]            hit_vec_o,
    output logic                    hit_any_o,
    output logic [IDX_W-1:0]        hit_idx_o
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec_o[g] = valid_i[g] && (keys_i[g] == key_i);
    end

    assign hit_any_o = |hit_vec_o;

    always_comb begin
        hit_idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec_o[i]) begin
                hit_idx_o = hit_idx_o | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
// Round-robin victim pick: first non-wired index at or after ptr_i.
module tlb_victim #(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     wired_i,
    input  logic [IDX_W-1:0] ptr_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             none_o
);

    always_comb begin
        logic found;
        int   j;
        found = 1'b0;
        idx_o = '0;
        for (int k = 0; k < N; k++) begin
            j = int'(ptr_i) + k;
            if (j >= N) begin
                j = j - N;
            end
            if (!found && !wired_i[j]) begin
                found = 1'b1;
                idx_o = IDX_W'(j);
            end
        end
        none_o = !found;
    end

endmodule

// File: rtl/tlb_perm.sv
`timescale 1ns/1ps
// Protection decision for one access against one entry's permission bits.
module tlb_perm
    import asid_tlb_pkg::*;
(
    input  acc_e  acc_i,
    input  perm_t perm_i,
    output logic  ok_o
);

    always_comb begin
        unique case (acc_i)
            ACC_READ:  ok_o = !perm_i.xo;
            ACC_WRITE: ok_o = !perm_i.xo && perm_i.rw;
            ACC_EXEC:  ok_o = perm_i.xo;
            default:   ok_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/asid_tlb.sv
`timescale 1ns/1ps
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int ASID_W  = 8,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PFN_W  = PA_W - OFF_W,
    localparam int KEY_W  = VPN_W + ASID_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [1:0]        lk_acc,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic [PA_W-1:0]   lk_pa,
    input  logic              rf_valid,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [ASID_W-1:0] rf_asid,
    input  logic [PFN_W-1:0]  rf_pfn,
    input  logic              rf_rw,
    input  logic              rf_xo,
    input  logic              rf_wired,
    output logic              rf_err,
    input  logic              fl_all,
    input  logic              fl_asid_en,
    input  logic [ASID_W-1:0] fl_asid
);

    typedef struct packed {
        logic              valid;
        logic              wired;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        perm_t             perm;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]   rr;
    } st_t;

    st_t st_d, st_q;

    // ---------------- per-entry views ----------------
    logic [ENTRIES-1:0]            valid_vec;
    logic [ENTRIES-1:0]            wired_vec;
    logic [ENTRIES-1:0][KEY_W-1:0] key_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_view
        assign valid_vec[g] = st_q.ent[g].valid;
        assign wired_vec[g] = st_q.ent[g].wired;
        assign key_vec[g]   = {st_q.ent[g].asid, st_q.ent[g].vpn};
    end

    // ---------------- lookup path ----------------
    logic [ENTRIES-1:0] lk_hitv;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_idx;
    logic               lk_ok;
    ent_t               lk_ent;

    tlb_cam #(.N(ENTRIES), .KEY_W(KEY_W)) u_cam_lk (
        .valid_i   (valid_vec),
        .keys_i    (key_vec),
        .key_i     ({lk_asid, lk_va[VA_W-1:OFF_W]}),
        .hit_vec_o (lk_hitv),
        .hit_any_o (lk_any),
        .hit_idx_o (lk_idx)
    );

    assign lk_ent = st_q.ent[lk_idx];

    tlb_perm u_perm (
        .acc_i  (acc_e'(lk_acc)),
        .perm_i (lk_ent.perm),
        .ok_o   (lk_ok)
    );

    always_comb begin
        lk_hit   = lk_valid && lk_any && lk_ok;
        lk_fault = lk_valid && lk_any && !lk_ok;
        lk_miss  = lk_valid && !lk_any;
        lk_pa    = lk_hit ? {lk_ent.pfn, lk_va[OFF_W-1:0]} : '0;
    end

    // ---------------- refill path ----------------
    logic [ENTRIES-1:0] rf_hitv;
    logic               rf_dup;
    logic [IDX_W-1:0]   rf_dup_idx;
    logic [IDX_W-1:0]   vic_idx;
    logic               vic_none;
    logic               rf_take;
    logic [IDX_W-1:0]   rf_tgt;
    logic [ENTRIES-1:0] wr_sel;

    tlb_cam #(.N(ENTRIES), .KEY_W(KEY_W)) u_cam_rf (
        .valid_i   (valid_vec),
        .keys_i    (key_vec),
        .key_i     ({rf_asid, rf_vpn}),
        .hit_vec_o (rf_hitv),
        .hit_any_o (rf_dup),
        .hit_idx_o (rf_dup_idx)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .wired_i (wired_vec),
        .ptr_i   (st_q.rr),
        .idx_o   (vic_idx),
        .none_o  (vic_none)
    );

    always_comb begin
        rf_err  = rf_valid && !rf_dup && vic_none;
        rf_take = rf_valid && !rf_err;
        rf_tgt  = rf_dup ? rf_dup_idx : vic_idx;
        for (int i = 0; i < ENTRIES; i++) begin
            wr_sel[i] = rf_take && (rf_tgt == IDX_W'(i));
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!st_q.ent[i].wired) begin
                if (fl_all) begin
                    st_d.ent[i].valid = 1'b0;
                end
                if (fl_asid_en && (st_q.ent[i].asid == fl_asid)) begin
                    st_d.ent[i].valid = 1'b0;
                end
            end
            if (wr_sel[i]) begin
                st_d.ent[i].valid   = 1'b1;
                st_d.ent[i].wired   = rf_wired;
                st_d.ent[i].asid    = rf_asid;
                st_d.ent[i].vpn     = rf_vpn;
                st_d.ent[i].pfn     = rf_pfn;
                st_d.ent[i].perm.rw = rf_rw;
                st_d.ent[i].perm.xo = rf_xo;
            end
        end
        if (rf_take && !rf_dup) begin
            if (int'(vic_idx) == ENTRIES - 1) begin
                st_d.rr = '0;
            end else begin
                st_d.rr = vic_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- assertions ----------------
    p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hitv) && $onehot0(rf_hitv))
        else $error("more than one entry matches a key");

    p_fault_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (!lk_hit && !lk_miss && (lk_pa == '0)))
        else $error("fault raised together with hit or miss");

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss && !lk_fault))
        else $error("lookup outputs active without a request");

    p_victim_unwired_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !vic_none |-> !wired_vec[vic_idx])
        else $error("victim points at a wired entry");

    p_reject_keeps_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_err |=> (st_q.rr == $past(st_q.rr)))
        else $error("rejected refill moved the pointer");

    p_flush_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_all && !rf_valid) |=> ((valid_vec & ~wired_vec) == '0))
        else $error("non-wired entry survived a full flush");

    for (genvar g = 0; g < ENTRIES; g++) begin : g_wired_chk
        p_wired_resident_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wired_vec[g] && !wr_sel[g]) |=> (valid_vec[g] && wired_vec[g]))
            else $error("wired entry lost without being rewritten");
    end

endmodule

// File: tb/sim_asid_tlb.sv
`timescale 1ns/1ps
module sim_asid_tlb;

    localparam int N      = 16;
    localparam int VA_W   = 32;
    localparam int PA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int ASID_W = 8;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PFN_W  = PA_W - OFF_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [VA_W-1:0]   lk_va = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic [1:0]        lk_acc = '0;
    logic              lk_hit, lk_miss, lk_fault;
    logic [PA_W-1:0]   lk_pa;
    logic              rf_valid = 1'b0;
    logic [VPN_W-1:0]  rf_vpn = '0;
    logic [ASID_W-1:0] rf_asid = '0;
    logic [PFN_W-1:0]  rf_pfn = '0;
    logic              rf_rw = 1'b0, rf_xo = 1'b0, rf_wired = 1'b0;
    logic              rf_err;
    logic              fl_all = 1'b0, fl_asid_en = 1'b0;
    logic [ASID_W-1:0] fl_asid = '0;

    always #4 clk = ~clk;  // 125 MHz

    asid_tlb u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid), .lk_acc(lk_acc),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_pa(lk_pa),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_pfn(rf_pfn),
        .rf_rw(rf_rw), .rf_xo(rf_xo), .rf_wired(rf_wired), .rf_err(rf_err),
        .fl_all(fl_all), .fl_asid_en(fl_asid_en), .fl_asid(fl_asid)
    );

    int n_run = 0;
    int n_fail = 0;

    // reference model
    bit              m_v  [N];
    bit              m_w  [N];
    bit [ASID_W-1:0] m_as [N];
    bit [VPN_W-1:0]  m_vp [N];
    bit [PFN_W-1:0]  m_pf [N];
    bit              m_rw [N];
    bit              m_xo [N];
    int              m_rr;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_w[i] = 0; m_as[i] = '0; m_vp[i] = '0;
            m_pf[i] = '0; m_rw[i] = 0; m_xo[i] = 0;
        end
        m_rr = 0;
    endfunction

    function automatic int model_find(bit [VPN_W-1:0] vpn, bit [ASID_W-1:0] as);
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_vp[i] == vpn && m_as[i] == as) return i;
        end
        return -1;
    endfunction

    function automatic bit model_all_wired();
        for (int i = 0; i < N; i++) if (!m_w[i]) return 0;
        return 1;
    endfunction

    // {hit, miss, fault, pa}
    function automatic logic [34:0] model_lookup(bit [VA_W-1:0] va, bit [ASID_W-1:0] as,
                                                 bit [1:0] acc);
        int  f;
        bit  ok;
        f = model_find(va[VA_W-1:OFF_W], as);
        if (f < 0) return {3'b010, 32'h0};
        case (acc)
            2'd0:    ok = !m_xo[f];
            2'd1:    ok = !m_xo[f] && m_rw[f];
            2'd2:    ok = m_xo[f];
            default: ok = 0;
        endcase
        if (!ok) return {3'b001, 32'h0};
        return {3'b100, m_pf[f], va[OFF_W-1:0]};
    endfunction

    function automatic void model_step(bit do_rf, bit [VPN_W-1:0] vpn, bit [ASID_W-1:0] as,
                                       bit [PFN_W-1:0] pfn, bit rw, bit xo, bit wd,
                                       bit fa, bit fae, bit [ASID_W-1:0] fas);
        int d, v;
        for (int i = 0; i < N; i++) begin
            if (!m_w[i] && (fa || (fae && m_as[i] == fas))) m_v[i] = 0;
        end
        if (!do_rf) return;
        d = -1;
        for (int i = 0; i < N; i++)  // duplicate search on pre-edge contents
            if (m_v_pre[i] && m_vp[i] == vpn && m_as[i] == as) d = i;
        if (d < 0) begin
            if (model_all_wired()) return;
            v = m_rr;
            while (m_w[v]) v = (v + 1) % N;
            m_rr = (v + 1) % N;
            d = v;
        end
        m_v[d] = 1; m_w[d] = wd; m_as[d] = as; m_vp[d] = vpn;
        m_pf[d] = pfn; m_rw[d] = rw; m_xo[d] = xo;
    endfunction

    bit m_v_pre [N];

    function automatic bit model_err(bit [VPN_W-1:0] vpn, bit [ASID_W-1:0] as);
        return (model_find(vpn, as) < 0) && model_all_wired();
    endfunction

    task automatic idle();
        rf_valid = 0; fl_all = 0; fl_asid_en = 0; lk_valid = 0;
    endtask

    // one clock of refill and/or flush; checks rf_err before the edge
    task automatic step(string req, bit do_rf, bit [VPN_W-1:0] vpn, bit [ASID_W-1:0] as,
                        bit [PFN_W-1:0] pfn, bit rw, bit xo, bit wd,
                        bit fa, bit fae, bit [ASID_W-1:0] fas);
        @(negedge clk);
        rf_valid = do_rf; rf_vpn = vpn; rf_asid = as; rf_pfn = pfn;
        rf_rw = rw; rf_xo = xo; rf_wired = wd;
        fl_all = fa; fl_asid_en = fae; fl_asid = fas;
        #2;
        if (do_rf) chk(req, 64'(rf_err), 64'(model_err(vpn, as)));
        else       chk(req, 64'(rf_err), 64'd0);
        for (int i = 0; i < N; i++) m_v_pre[i] = m_v[i];
        @(posedge clk);
        #1;
        idle();
        model_step(do_rf, vpn, as, pfn, rw, xo, wd, fa, fae, fas);
    endtask

    task automatic rfill(string req, bit [VPN_W-1:0] vpn, bit [ASID_W-1:0] as,
                         bit [PFN_W-1:0] pfn, bit rw, bit xo, bit wd);
        step(req, 1, vpn, as, pfn, rw, xo, wd, 0, 0, '0);
    endtask

    task automatic look(string req, bit [VA_W-1:0] va, bit [ASID_W-1:0] as, bit [1:0] acc);
        @(negedge clk);
        lk_valid = 1; lk_va = va; lk_asid = as; lk_acc = acc;
        #2;
        chk(req, 64'({lk_hit, lk_miss, lk_fault, lk_pa}), 64'(model_lookup(va, as, acc)));
        lk_valid = 0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        model_reset();
    endtask

    function automatic bit [VA_W-1:0] mkva(int vpn, int off);
        return {VPN_W'(vpn), OFF_W'(off)};
    endfunction

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int wcount;
        void'($urandom(32'h5eed_1234));
        do_reset();

        // R10: reset state
        @(negedge clk); #2;
        chk("R10 idle outputs", 64'({lk_hit, lk_miss, lk_fault, lk_pa}), 64'd0);
        look("R10 empty after reset", mkva(3, 5), 8'd1, 2'd0);

        // R1/R3: refill then hit, offset passes through
        rfill("R3 refill", 20'h00003, 8'd1, 20'hABCDE, 1, 0, 0);
        look("R1 hit read", mkva(3, 12'h7F1), 8'd1, 2'd0);
        look("R1 hit write", mkva(3, 12'h004), 8'd1, 2'd1);
        // R2: identifier mismatch
        look("R2 asid mismatch", mkva(3, 12'h004), 8'd2, 2'd0);
        look("R2 vpn mismatch", mkva(4, 12'h004), 8'd1, 2'd0);

        // R7: protection
        rfill("R7 ro entry", 20'h00010, 8'd1, 20'h11111, 0, 0, 0);
        rfill("R7 xo entry", 20'h00011, 8'd1, 20'h22222, 0, 1, 0);
        look("R7 ro write fault", mkva(16, 1), 8'd1, 2'd1);
        look("R7 ro read ok", mkva(16, 1), 8'd1, 2'd0);
        look("R7 ro exec fault", mkva(16, 1), 8'd1, 2'd2);
        look("R7 xo exec ok", mkva(17, 1), 8'd1, 2'd2);
        look("R7 xo read fault", mkva(17, 1), 8'd1, 2'd0);
        look("R7 reserved fault", mkva(3, 1), 8'd1, 2'd3);

        // R3: overwrite in place
        rfill("R3 overwrite", 20'h00003, 8'd1, 20'h0BEEF, 1, 0, 0);
        look("R3 new frame", mkva(3, 9), 8'd1, 2'd0);

        // R4: fill all, the 17th new pair evicts the oldest round-robin slot
        do_reset();
        for (int i = 0; i < N; i++) rfill("R4 fill", 20'(100 + i), 8'd7, 20'(i + 1), 1, 0, 0);
        rfill("R4 evict", 20'd500, 8'd7, 20'd77, 1, 0, 0);
        look("R4 slot0 evicted", mkva(100, 0), 8'd7, 2'd0);
        look("R4 slot1 kept", mkva(101, 0), 8'd7, 2'd0);
        look("R4 new present", mkva(500, 0), 8'd7, 2'd0);

        // R9: flush by identifier
        rfill("R9 other asid", 20'd600, 8'd9, 20'd5, 1, 0, 0);
        step("R9 flush asid", 0, '0, '0, '0, 0, 0, 0, 0, 1, 8'd7);
        look("R9 asid7 gone", mkva(105, 0), 8'd7, 2'd0);
        look("R9 asid9 kept", mkva(600, 0), 8'd9, 2'd0);

        // R5/R8: wired survives flush-all
        rfill("R5 wired", 20'd700, 8'd3, 20'd9, 1, 0, 1);
        step("R8 flush all", 0, '0, '0, '0, 0, 0, 0, 1, 0, '0);
        look("R8 non-wired gone", mkva(600, 0), 8'd9, 2'd0);
        look("R5 wired kept", mkva(700, 0), 8'd3, 2'd0);

        // R11: flush and refill in one cycle
        step("R11 flush+refill", 1, 20'd800, 8'd4, 20'd44, 1, 0, 0, 1, 0, '0);
        look("R11 refilled valid", mkva(800, 3), 8'd4, 2'd0);

        // R6: all wired
        do_reset();
        for (int i = 0; i < N; i++) rfill("R6 wire all", 20'(i), 8'd2, 20'(i + 32), 0, 0, 1);
        rfill("R6 reject", 20'd999, 8'd2, 20'd1, 1, 0, 0);
        look("R6 rejected absent", mkva(999, 0), 8'd2, 2'd0);
        for (int i = 0; i < N; i++) look("R5 all wired kept", mkva(i, 1), 8'd2, 2'd0);
        rfill("R3 unwire by overwrite", 20'd5, 8'd2, 20'd55, 1, 0, 0);
        rfill("R4 refill after unwire", 20'd999, 8'd2, 20'd66, 1, 0, 0);
        look("R4 took freed slot", mkva(999, 0), 8'd2, 2'd0);
        look("R4 freed pair evicted", mkva(5, 0), 8'd2, 2'd0);

        // random mix against the model
        do_reset();
        for (int it = 0; it < 3000; it++) begin
            int op;
            op = int'($urandom % 100);
            wcount = 0;
            for (int i = 0; i < N; i++) wcount += int'(m_w[i]);
            if (op < 55) begin
                look("R1 R2 R7 random lookup",
                     mkva(int'($urandom % 24), int'($urandom % 4096)),
                     8'($urandom % 3), 2'($urandom % 4));
            end else if (op < 93) begin
                step("R3 R4 random refill", 1, 20'($urandom % 24), 8'($urandom % 3),
                     20'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
                     (wcount < N - 2) && ($urandom % 16 == 0),
                     ($urandom % 40 == 0), 0, '0);
            end else if (op < 97) begin
                step("R9 random flush asid", 0, '0, '0, '0, 0, 0, 0, 0, 1, 8'($urandom % 3));
            end else begin
                step("R8 random flush all", 0, '0, '0, '0, 0, 0, 0, 1, 0, '0);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule